// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block is a multicycle integer unit. It multiplies by shift-and-add and divides by restoring shift-and-subtract. One adder and one shifting pair of working registers serve all four operations, and each clock retires one multiplier bit or one quotient bit. A caller pulses `start` with an operation code and two operands. `busy` is high while the unit works. `done` pulses when the 64-bit result has been written to the `hi` and `lo` outputs.

Signed operations run on operand magnitudes, and the unit fixes the result signs in one final cycle. A multiply writes the upper product half to `hi` and the lower half to `lo`. A divide writes the remainder to `hi` and the quotient to `lo`. The unit checks neither for a zero divisor nor for overflow. Every operation takes the same number of clocks.

Top module: `muldiv_seq`

## Requirements
- R1: When `start` is high at a rising edge and `busy` is low, the unit latches `op` and both operands at that edge and raises `busy` from the next cycle. Once latched, later changes on the operand inputs have no effect. `op` encoding: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R2: `done` goes high for exactly one cycle, WIDTH+1 rising edges after the edge that accepted `start`. `busy` is low in that cycle.
- R3: Unsigned multiply puts bits [2W-1:W] of the 2W-bit product in `hi` and bits [W-1:0] in `lo`.
- R4: Signed multiply gives the two's-complement 2W-bit product with the same placement, including for the most negative operand.
- R5: Unsigned divide with a nonzero divisor puts the quotient in `lo` and the remainder in `hi`.
- R6: Signed divide truncates toward zero. The quotient is negative when exactly one operand is negative, and the remainder takes the dividend's sign. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R7: Unsigned divide by zero gives `lo` all ones and `hi` equal to the dividend. A signed divide by zero gives `hi` equal to the dividend and `lo` equal to 1 for a negative dividend, otherwise all ones. Both take the normal cycle count.
- R8: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands and timing, and no second operation follows it.
- R9: `hi` and `lo` change only in the cycle `done` rises. They hold their values while an operation runs and while the unit is idle.
- R10: After reset, `busy`, `done`, `hi` and `lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation code (see R1) |
| opa | input | WIDTH | Multiplicand or dividend |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | WIDTH | Product high half or remainder |
| lo | output | WIDTH | Product low half or quotient |

## Verification
With WIDTH of 32, every result is due exactly 33 rising edges after the edge that accepts `start`, and `busy` is due one edge after it. The bench drives inputs on falling edges and counts falling edges from the accepting edge. It requires the first `done` it sees to fall on count 33, and it compares `hi`/`lo` against bench arithmetic in that same sample. At every falling edge before that count, it checks that `hi`/`lo` still hold the previous result. One falling edge after `done`, it checks that both `done` and `busy` are low, which shows that an injected mid-run start left no trace.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic take,
  output logic step_en,
  output logic fix_en
);
  import muldiv_pkg::*;
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  md_state_e       state;
  logic [CW-1:0]   step_cnt;

  assign busy    = (state != ST_IDLE);
  assign take    = start && (state == ST_IDLE);
  assign step_en = (state == ST_RUN);
  assign fix_en  = (state == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state    <= ST_RUN;
          step_cnt <= '0;
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_adder.sv
module muldiv_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   x,
  input  logic [WIDTH:0]   y,
  input  logic             cin,
  output logic [WIDTH+1:0] sum
);
  function automatic logic [WIDTH+1:0] add_ext(input logic [WIDTH:0] a,
                                               input logic [WIDTH:0] b,
                                               input logic c);
    return {1'b0, a} + {1'b0, b} + {{(WIDTH+1){1'b0}}, c};
  endfunction

  assign sum = add_ext(x, y, cin);
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
  parameter int WIDTH = 32
) (
  input  logic             is_div,
  input  logic             neg_main,
  input  logic             neg_rem,
  input  logic [WIDTH-1:0] work_h,
  input  logic [WIDTH-1:0] work_l,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  localparam int PW = 2 * WIDTH;

  function automatic logic [PW-1:0] neg_if_wide(input logic [PW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [WIDTH-1:0] neg_if(input logic [WIDTH-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  logic [PW-1:0] prod;
  assign prod = neg_if_wide({work_h, work_l}, neg_main);

  always_comb begin
    if (is_div) begin
      res_hi = neg_if(work_h, neg_rem);
      res_lo = neg_if(work_l, neg_main);
    end else begin
      res_hi = prod[PW-1:WIDTH];
      res_lo = prod[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  import muldiv_pkg::*;
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[MSB]) ? (~v + 1'b1) : v;
  endfunction

  // named events for the checker
  logic take, step_en, fix_en;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .take(take), .step_en(step_en), .fix_en(fix_en)
  );

  md_op_e op_e;
  logic   op_div, op_sgn;
  assign op_e   = md_op_e'(op);
  assign op_div = (op_e == OP_DIVS) || (op_e == OP_DIVU);
  assign op_sgn = (op_e == OP_DIVS) || (op_e == OP_MULS);

  logic [WIDTH-1:0] work_h, work_l, opnd;
  logic             div_q, neg_q, rneg_q;

  // shared adder
  logic [WIDTH:0]   add_x, add_y;
  logic [WIDTH+1:0] add_s;
  logic             fits;

  always_comb begin
    if (div_q) begin
      add_x = {work_h, work_l[MSB]};
      add_y = ~{1'b0, opnd};
    end else begin
      add_x = {1'b0, work_h};
      add_y = {1'b0, work_l[0] ? opnd : {WIDTH{1'b0}}};
    end
  end

  muldiv_adder #(.WIDTH(WIDTH)) u_add (
    .x(add_x), .y(add_y), .cin(div_q), .sum(add_s)
  );

  assign fits = add_s[WIDTH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_h <= '0;
      work_l <= '0;
      opnd   <= '0;
      div_q  <= 1'b0;
      neg_q  <= 1'b0;
      rneg_q <= 1'b0;
    end else if (take) begin
      work_h <= '0;
      work_l <= op_div ? magnitude(opa, op_sgn) : magnitude(opb, op_sgn);
      opnd   <= op_div ? magnitude(opb, op_sgn) : magnitude(opa, op_sgn);
      div_q  <= op_div;
      neg_q  <= op_sgn && (opa[MSB] ^ opb[MSB]);
      rneg_q <= op_sgn && op_div && opa[MSB];
    end else if (step_en) begin
      if (div_q) begin
        work_h <= fits ? add_s[WIDTH-1:0] : add_x[WIDTH-1:0];
        work_l <= {work_l[MSB-1:0], fits};
      end else begin
        work_h <= add_s[WIDTH:1];
        work_l <= {add_s[0], work_l[MSB:1]};
      end
    end
  end

  logic [WIDTH-1:0] res_hi, res_lo;

  muldiv_fix #(.WIDTH(WIDTH)) u_fix (
    .is_div(div_q), .neg_main(neg_q), .neg_rem(rneg_q),
    .work_h(work_h), .work_l(work_l), .res_hi(res_hi), .res_lo(res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else begin
      done <= fix_en;
      if (fix_en) begin
        hi <= res_hi;
        lo <= res_lo;
      end
    end
  end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo,
  input logic             take,
  input logic             step_en,
  input logic             fix_en
);
  localparam int KW = $clog2(WIDTH + 3) + 1;

  logic [KW-1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     edges <= '0;
    else if (take)  edges <= '0;
    else if (busy)  edges <= edges + 1'b1;
  end

  p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy && !done));

  p_done_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edges == KW'(WIDTH + 1)) && !busy);

  p_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |-> (edges == KW'(WIDTH)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && start) |=> (busy && !done));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_en |=> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_seq muldiv_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hi(hi), .lo(lo), .take(take), .step_en(step_en), .fix_en(fix_en)
);

// File: tb/muldiv_seq_bench.sv
module muldiv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] opa = '0, opb = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_seq #(.WIDTH(W)) u_muldiv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] o, input logic [W-1:0] b);
    case (o)
      2'b00:   return "R4";
      2'b01:   return "R3";
      2'b10:   return (b == 0) ? "R7" : "R6";
      default: return (b == 0) ? "R7" : "R5";
    endcase
  endfunction

  // returns {hi, lo}
  function automatic logic [63:0] expect_of(input logic [1:0] o,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    longint sa, sb, sq, sr;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (o)
      2'b01: return ua * ub;
      2'b00: return 64'(sa * sb);
      2'b11: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {32'(ua % ub), 32'(ua / ub)};
      end
      default: begin
        if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        sq = sa / sb;
        sr = sa % sb;
        return {32'(sr), 32'(sq)};
      end
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit inject);
    logic [63:0] prev, exp;
    string       req;
    int          k;
    bit          hold_bad;
    req  = req_of(o, b);
    exp  = expect_of(o, a, b);
    @(negedge clk);
    prev = {hi, lo};
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    check("R1", "busy after accept", 64'(busy), 64'd1);
    opa = ~a; opb = b + 32'd3; op = ~o;   // latched values must be used (R1)
    k = 0;
    hold_bad = 0;
    while (k < 100) begin
      if (inject && k == 4) begin
        start = 1'b1; opa = 32'h0000_1234; opb = 32'h0000_0007;   // R8 stimulus
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
      if (done) break;
      if ({hi, lo} !== prev) hold_bad = 1;
    end
    start = 1'b0;
    check("R9", "hi/lo held while running", 64'(hold_bad), 64'd0);
    check("R2", "edges to done", 64'(k), 64'(W + 1));
    check("R2", "busy low at done", 64'(busy), 64'd0);
    check(req, $sformatf("op=%0d a=%h b=%h {hi,lo}", o, a, b), {hi, lo}, exp);
    @(negedge clk);
    check("R2", "done is one cycle", 64'(done), 64'd0);
    if (inject) check("R8", "no operation after ignored start", 64'(busy), 64'd0);
    check("R9", "hi/lo held when idle", {hi, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R10", "busy after reset", 64'(busy), 64'd0);
    check("R10", "done after reset", 64'(done), 64'd0);
    check("R10", "hi/lo after reset", {hi, lo}, 64'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R3
    run_op(2'b01, 32'd7, 32'd6, 0);                  // R3
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R4
    run_op(2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 0);  // R4
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0);  // R4
    run_op(2'b00, 32'hFFFF_FFFB, 32'd3, 1);          // R4 + R8
    run_op(2'b11, 32'd74, 32'd8, 0);                 // R5
    run_op(2'b11, 32'hFFFF_FFFF, 32'd1, 0);          // R5
    run_op(2'b11, 32'hDEAD_BEEF, 32'd0, 0);          // R7
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0);          // R6: -7/2
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0);          // R6: 7/-2
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R6 overflow case
    run_op(2'b10, 32'hFFFF_FFF9, 32'd0, 0);          // R7 signed
    run_op(2'b10, 32'd9, 32'd0, 1);                  // R7 + R8

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [1:0]   ro;
      logic [W-1:0] ra, rb;
      ro = 2'($urandom % 4);
      ra = $urandom;
      rb = $urandom;
      if ((i % 3) == 0) rb = rb >> ($urandom % 32);
      run_op(ro, ra, rb, (i % 7) == 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule